// File: doc/BRIEF.md
# Two-Port Interleaving Sample Front End for a Converter Core

This block sits in front of a converter core that updates at a fast clock. Two parallel sample ports each run at half that rate. A divide-by-two derived from the fast clock sets the slow capture instant. The divided clock is driven out on `sync_out`, so that upstream logic can launch its data on the edge that will be captured. A reset pulse puts the divider into a known phase. The number of fast edges between reset release and the first capture is therefore fixed, and a source can line up its data with one chosen edge.

In dual mode, both ports are taken on every capture edge. The output code register then gives the first port's sample on that edge and the second port's sample on the following edge, so a continuous stream comes out at the fast rate. In single mode, one port is chosen by a select input and the block acts as a two-stage buffer. The chosen port is held in its input latch at one capture and reaches the output at the next. A strobe marks every output update.

Top module: `dac_interleave_if`

## Requirements
- R1: Each port carries DATA_W bits (10 by default). A code passes to `dac_code` without change across the full range, from 0 to 1023.
- R2: `sync_out` is 1 while `sync_rst` is high and on the first two fast edges after its release. Those two edges are the latency of the reset synchroniser.
- R3: On the third fast edge after release, `sync_out` falls to 0. After that it toggles on every fast edge: each 0 is followed by a 1 and each 1 by a 0.
- R4: The first capture happens on the fourth fast edge after release. On that edge `sync_out` rises, both ports are captured and `code_vld` goes high.
- R5: With `il_mode`=1 (dual), each capture edge loads `dac_code` with `port_a` as presented at that edge. The next fast edge loads the `port_b` value taken at the same capture. From the first capture on, `code_vld` stays high.
- R6: Port values that change between capture edges have no effect on `dac_code`.
- R7: With `il_mode`=0 (single), `port_sel` is sampled at each capture. A value of 0 chooses `port_a` and 1 chooses `port_b`. The chosen port is latched, and it appears on `dac_code` at the next capture, one slow period later.
- R8: In single mode, `code_vld` is high for exactly one fast cycle at each capture after the first. Between those pulses, `dac_code` holds its value.
- R9: In single mode, the port that is not chosen has no effect on `dac_code`.
- R10: A high `sync_rst` sets `dac_code` to 0 and `code_vld` to 0 at once. The two outputs stay at 0 until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the output update rate |
| sync_rst | input | 1 | Active-high alignment reset. Asserts asynchronously and is released through a synchroniser |
| il_mode | input | 1 | 1 selects dual interleaving, 0 selects the single-port buffer. Change it only while in reset |
| port_sel | input | 1 | Single mode only: 0 chooses port_a, 1 chooses port_b |
| port_a | input | DATA_W | First sample port |
| port_b | input | DATA_W | Second sample port |
| dac_code | output | DATA_W | Code register that feeds the converter core |
| code_vld | output | 1 | High on each fast cycle in which dac_code was updated |
| sync_out | output | 1 | Divided slow clock. Its rising edge marks a capture |

## Verification
If the divider is one edge out of phase, `sync_out` shows the error on the third edge after release, and `dac_code` shows a second port's sample where a first port's sample is expected. A fault in the synchroniser depth moves the first rise of `code_vld` away from the fourth edge, so counting edges from release finds it at once. A wrong latch enable or a stale select shows up one slow period later, either as a value that should have been ignored appearing on `dac_code` or as the wrong port's value at the next capture.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_DUAL   = 1'b1
   } if_mode_e;

   localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/dac_clk_div.sv
module dac_clk_div #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_async,
   output logic rst_q,
   output logic div_clk,
   output logic cap_pulse
);
   localparam int unsigned MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("dac_clk_div: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_sr;

   always_ff @(posedge clk or posedge rst_async) begin
      if (rst_async) sync_sr <= '1;
      else           sync_sr <= {sync_sr[MSB-1:0], 1'b0};
   end

   assign rst_q = sync_sr[MSB];

   always_ff @(posedge clk or posedge rst_async) begin
      if (rst_async)  div_clk <= 1'b1;
      else if (rst_q) div_clk <= 1'b1;
      else            div_clk <= ~div_clk;
   end

   // the slow clock rises on this edge
   assign cap_pulse = ~rst_q & ~div_clk;
endmodule

// File: rtl/dac_in_latch.sv
module dac_in_latch #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned PORTS  = 2
) (
   input  logic                         clk,
   input  logic                         rst_async,
   input  logic [PORTS-1:0][DATA_W-1:0] din,
   input  logic [PORTS-1:0]             load,
   output logic [PORTS-1:0][DATA_W-1:0] q
);
   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk or posedge rst_async) begin
         if (rst_async)    q[p] <= '0;
         else if (load[p]) q[p] <= din[p];
      end
   end
endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg
   import dac_if_pkg::*;
#(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned PORTS  = 2
) (
   input  logic                         clk,
   input  logic                         rst_async,
   input  logic                         rst_q,
   input  if_mode_e                     mode,
   input  logic                         cap_pulse,
   input  logic                         div_clk,
   input  logic                         sel,
   input  logic [DATA_W-1:0]            first_in,
   input  logic [PORTS-1:0][DATA_W-1:0] latched,
   output logic [DATA_W-1:0]            code,
   output logic                         vld
);
   logic primed;
   logic sel_q;

   always_ff @(posedge clk or posedge rst_async) begin
      if (rst_async) begin
         code   <= '0;
         vld    <= 1'b0;
         primed <= 1'b0;
         sel_q  <= 1'b0;
      end else if (rst_q) begin
         code   <= '0;
         vld    <= 1'b0;
         primed <= 1'b0;
         sel_q  <= 1'b0;
      end else if (mode == MODE_DUAL) begin
         if (cap_pulse) begin
            code   <= first_in;
            vld    <= 1'b1;
            primed <= 1'b1;
         end else if (primed && div_clk) begin
            code <= latched[1];
            vld  <= 1'b1;
         end else begin
            vld <= 1'b0;
         end
      end else begin
         if (cap_pulse) begin
            code   <= latched[sel_q];
            vld    <= primed;
            primed <= 1'b1;
            sel_q  <= sel;
         end else begin
            vld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dac_interleave_if.sv
module dac_interleave_if
   import dac_if_pkg::*;
#(
   parameter int unsigned DATA_W      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              sync_rst,
   input  logic              il_mode,
   input  logic              port_sel,
   input  logic [DATA_W-1:0] port_a,
   input  logic [DATA_W-1:0] port_b,
   output logic [DATA_W-1:0] dac_code,
   output logic              code_vld,
   output logic              sync_out
);
   localparam int unsigned PORTS = NUM_PORTS;

   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("dac_interleave_if: DATA_W out of range");
   end

   logic                         rst_q;
   logic                         cap_pulse;
   logic [PORTS-1:0]             load;
   logic [PORTS-1:0][DATA_W-1:0] din;
   logic [PORTS-1:0][DATA_W-1:0] latched;
   if_mode_e                     mode;

   assign mode   = if_mode_e'(il_mode);
   assign din[0] = port_a;
   assign din[1] = port_b;

   for (genvar p = 0; p < PORTS; p++) begin : g_load
      assign load[p] = cap_pulse &
                       ((mode == MODE_DUAL) || (port_sel == p[0]));
   end

   dac_clk_div #(.SYNC_STAGES(SYNC_STAGES)) u_div (
      .clk       (clk),
      .rst_async (sync_rst),
      .rst_q     (rst_q),
      .div_clk   (sync_out),
      .cap_pulse (cap_pulse)
   );

   dac_in_latch #(.DATA_W(DATA_W), .PORTS(PORTS)) u_latch (
      .clk       (clk),
      .rst_async (sync_rst),
      .din       (din),
      .load      (load),
      .q         (latched)
   );

   dac_code_reg #(.DATA_W(DATA_W), .PORTS(PORTS)) u_code (
      .clk       (clk),
      .rst_async (sync_rst),
      .rst_q     (rst_q),
      .mode      (mode),
      .cap_pulse (cap_pulse),
      .div_clk   (sync_out),
      .sel       (port_sel),
      .first_in  (port_a),
      .latched   (latched),
      .code      (dac_code),
      .vld       (code_vld)
   );
endmodule

// File: rtl/dac_interleave_if_chk.sv
module dac_interleave_if_chk #(
   parameter int unsigned DATA_W = 10
) (
   input logic              clk,
   input logic              sync_rst,
   input logic              il_mode,
   input logic [DATA_W-1:0] port_a,
   input logic [DATA_W-1:0] dac_code,
   input logic              code_vld,
   input logic              sync_out
);
   a_r2_sync_high_in_reset: assert property (@(posedge clk)
      sync_rst |-> sync_out);

   a_r3_low_then_high: assert property (@(posedge clk) disable iff (sync_rst)
      !$past(sync_out) |-> sync_out);

   a_r5_first_port_on_rise: assert property (@(posedge clk) disable iff (sync_rst)
      (il_mode && $rose(sync_out) && code_vld) |-> dac_code == $past(port_a));

   a_r5_stream_unbroken: assert property (@(posedge clk) disable iff (sync_rst)
      (il_mode && $past(code_vld)) |-> code_vld);

   a_r8_single_vld_on_rise: assert property (@(posedge clk) disable iff (sync_rst)
      (!il_mode && code_vld) |-> $rose(sync_out));

   a_r8_single_hold: assert property (@(posedge clk) disable iff (sync_rst)
      (!il_mode && !code_vld) |-> $stable(dac_code));

   a_r10_reset_clears: assert property (@(posedge clk)
      $past(sync_rst) |-> (!code_vld && dac_code == '0));
endmodule

bind dac_interleave_if dac_interleave_if_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .sync_rst (sync_rst),
   .il_mode  (il_mode),
   .port_a   (port_a),
   .dac_code (dac_code),
   .code_vld (code_vld),
   .sync_out (sync_out)
);

// File: tb/tb_dac_interleave_if.sv
module tb_dac_interleave_if;
   localparam int unsigned W = 10;
   localparam int unsigned NV = 6;
   localparam logic [W-1:0] JUNK = 10'h3C3;

   typedef struct packed {
      logic [W-1:0] a;
      logic [W-1:0] b;
   } pair_t;

   localparam pair_t VEC [NV] = '{
      '{a: 10'h2AA, b: 10'h155},
      '{a: 10'h000, b: 10'h3FF},
      '{a: 10'h3FF, b: 10'h000},
      '{a: 10'h001, b: 10'h200},
      '{a: 10'h0F0, b: 10'h00F},
      '{a: 10'h123, b: 10'h321}
   };

   logic         clk = 1'b0;
   logic         sync_rst;
   logic         il_mode;
   logic         port_sel;
   logic [W-1:0] port_a;
   logic [W-1:0] port_b;
   logic [W-1:0] dac_code;
   logic         code_vld;
   logic         sync_out;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   dac_interleave_if #(.DATA_W(W)) dut (
      .clk      (clk),
      .sync_rst (sync_rst),
      .il_mode  (il_mode),
      .port_sel (port_sel),
      .port_a   (port_a),
      .port_b   (port_b),
      .dac_code (dac_code),
      .code_vld (code_vld),
      .sync_out (sync_out)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 5000);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      sync_rst = 1'b1;
      il_mode  = 1'b1;
      port_sel = 1'b0;
      port_a   = '0;
      port_b   = '0;
      step(); step(); step();
      // R10 R2: reset state
      chk(dac_code == 0, "R10 code", int'(dac_code), 0);
      chk(code_vld == 0, "R10 vld", int'(code_vld), 0);
      chk(sync_out == 1, "R2 sync in reset", int'(sync_out), 1);

      // dual mode: edge count from release
      port_a   = VEC[0].a;
      port_b   = VEC[0].b;
      sync_rst = 1'b0;
      step();
      chk(sync_out == 1 && !code_vld, "R2 edge1", int'(sync_out), 1);
      step();
      chk(sync_out == 1 && !code_vld, "R2 edge2", int'(sync_out), 1);
      step();
      chk(sync_out == 0 && !code_vld, "R3 edge3", int'(sync_out), 0);
      step();
      chk(sync_out == 1, "R4 edge4 sync", int'(sync_out), 1);
      chk(code_vld == 1, "R4 edge4 vld", int'(code_vld), 1);
      chk(dac_code == VEC[0].a, "R4 R1 first capture", int'(dac_code), int'(VEC[0].a));
      port_a = JUNK;
      port_b = JUNK;
      step();
      chk(dac_code == VEC[0].b, "R5 R6 second port", int'(dac_code), int'(VEC[0].b));
      chk(sync_out == 0, "R3 toggle", int'(sync_out), 0);

      for (int i = 1; i < NV; i++) begin
         port_a = VEC[i].a;
         port_b = VEC[i].b;
         step();
         chk(dac_code == VEC[i].a && code_vld && sync_out,
             "R5 R1 first port", int'(dac_code), int'(VEC[i].a));
         port_a = JUNK;
         port_b = JUNK;
         step();
         chk(dac_code == VEC[i].b && code_vld && !sync_out,
             "R5 R6 second port", int'(dac_code), int'(VEC[i].b));
      end

      // single mode
      @(negedge clk);
      sync_rst = 1'b1;
      il_mode  = 1'b0;
      port_sel = 1'b0;
      port_a   = 10'h0F1;
      port_b   = 10'h222;
      step(); step();
      chk(dac_code == 0 && !code_vld, "R10 reset after data", int'(dac_code), 0);
      sync_rst = 1'b0;
      step(); step(); step();
      step();
      chk(!code_vld, "R8 first capture not valid", int'(code_vld), 0);
      chk(dac_code == 0, "R7 latency", int'(dac_code), 0);
      step();
      chk(!code_vld, "R8 between captures", int'(code_vld), 0);
      port_sel = 1'b1;
      port_b   = 10'h333;
      port_a   = 10'h3FF;
      step();
      chk(dac_code == 10'h0F1 && code_vld, "R7 port_a after one period", int'(dac_code), 'h0F1);
      step();
      chk(!code_vld && dac_code == 10'h0F1, "R8 hold", int'(dac_code), 'h0F1);
      port_a = 10'h1AB;
      port_b = 10'h044;
      step();
      chk(dac_code == 10'h333 && code_vld, "R7 port_b selected", int'(dac_code), 'h333);
      step();
      port_a = 10'h2CD;
      step();
      chk(dac_code == 10'h044, "R9 unselected ignored", int'(dac_code), 'h044);
      chk(code_vld, "R8 pulse", int'(code_vld), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule